// File: doc/BRIEF.md
# Link Power Management Handshake Responder

This block sits on the device side of a USB link. It decides how to answer a Link Power Management (LPM) token that the packet decoder has already parsed and checked. When the decoder raises a one-cycle strobe, the block reads the strobe's LinkState, resume-duration (HIRD) and remote-wake fields. It combines them with three inputs: the two-bit LPM enable code, the software transmit-ready bit, and the pending-data flag from the transmit endpoint FIFOs. From these it picks a handshake: no answer (the host times out), STALL, NYET or ACK.

Every answered token raises a response interrupt that carries the handshake code. A token whose LinkState is not a suspend request also raises an error interrupt. The received attributes are held in a register so that software can read them. After an ACK, a short guard window opens. During that window a repeated token is acknowledged again, because the host may not have seen the first ACK. The window length is a cycle-count parameter sized to the 9 µs guard at the system clock.

Top module: `lpm_responder`

## Requirements
- R1: When the enable code has bit 0 clear (values 2'b00 and 2'b10), a strobe produces no handshake, no interrupt of either kind and no change to the attribute register.
- R2: With enable code 2'b01, every strobe is answered with STALL (code 0), whatever the other inputs are, and no error interrupt is raised.
- R3: With enable code 2'b11 and a LinkState other than 4'h1, the answer is STALL (code 0), the error interrupt pulses together with the handshake, and the attributes are still latched.
- R4: With enable code 2'b11, LinkState 4'h1 and the guard window closed, the answer is ACK (code 2) only when transmit-ready is 1 and no FIFO data is pending; otherwise it is NYET (code 1).
- R5: A strobe with enable code 2'b11 and LinkState 4'h1 is answered with ACK regardless of transmit-ready and pending data when it is sampled on one of the WINDOW_CYCLES clock edges that follow the edge on which a previous ACK appeared. An ACK given in this way restarts the window.
- R6: On every answered strobe, the attribute register takes LinkState in bits [3:0], HIRD in bits [7:4] and remote-wake in bit 8. It holds its value otherwise.
- R7: Each handshake comes with a one-cycle response interrupt whose two-bit code equals the handshake code: 0 STALL, 1 NYET, 2 ACK.
- R8: The handshake valid is a one-cycle pulse that appears on the second rising edge after the edge that samples the strobe, and at no other time.
- R9: While reset is high and after it is released, all outputs are zero and the guard window is closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lpm_stb | input | 1 | One-cycle strobe: a checked LPM token was received |
| lpm_en | input | 2 | LPM enable code from software |
| tx_ready | input | 1 | Software is ready to suspend |
| tx_pending | input | 1 | Some transmit FIFO holds data |
| pkt_link_state | input | 4 | LinkState field of the token |
| pkt_hird | input | 4 | Resume-duration field of the token |
| pkt_remote_wake | input | 1 | Remote-wake permission of the token |
| hs_valid | output | 1 | Handshake to be sent this cycle |
| hs_code | output | 2 | Handshake: 0 STALL, 1 NYET, 2 ACK |
| rsp_irq | output | 1 | Response interrupt pulse |
| rsp_code | output | 2 | Handshake code carried with the interrupt |
| err_irq | output | 1 | Non-compliant LinkState interrupt pulse |
| attr_q | output | 9 | Latched attributes {remote-wake, HIRD, LinkState} |

## Verification
The assertions assume the strobe is a single-cycle pulse with at least one idle cycle between strobes, as the decoder delivers it. They also assume the enable code and the packet fields are stable on the edge that samples the strobe. The stimulus drives every field at a falling edge, holds the strobe for exactly one cycle, and spaces tokens by at least two idle cycles. The window tests control the gap in cycles so that a strobe lands exactly on the last edge inside the window and exactly on the first edge outside it.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  parameter int LPM_LS_W   = 4;
  parameter int LPM_HIRD_W = 4;
  parameter int LPM_ATTR_W = LPM_LS_W + LPM_HIRD_W + 1;

  localparam logic [LPM_LS_W-1:0] LS_SUSPEND = LPM_LS_W'(1);

  typedef enum logic [1:0] {
    HS_STALL = 2'd0,
    HS_NYET  = 2'd1,
    HS_ACK   = 2'd2
  } hs_code_t;

  typedef struct packed {
    logic                  rwake;
    logic [LPM_HIRD_W-1:0] hird;
    logic [LPM_LS_W-1:0]   lstate;
  } lpm_attr_t;
endpackage

// File: rtl/lpm_window.sv
module lpm_window #(
  parameter int WINDOW_CYCLES = 540
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic open_o
);
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CNT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign open_o = (cnt_q != '0);
endmodule

// File: rtl/lpm_decide.sv
module lpm_decide
  import lpm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  stb,
  input  logic [1:0]            en,
  input  logic                  tx_ready,
  input  logic                  tx_pending,
  input  logic [LPM_LS_W-1:0]   lstate,
  input  logic [LPM_HIRD_W-1:0] hird,
  input  logic                  rwake,
  input  logic                  win_open,
  output logic                  s1_valid,
  output hs_code_t              s1_code,
  output logic                  s1_err,
  output lpm_attr_t             s1_attr
);
  logic     respond;
  logic     bad_ls;
  hs_code_t code_d;
  logic     err_d;

  always_comb begin
    respond = stb && en[0];
    bad_ls  = (lstate != LS_SUSPEND);
    err_d   = 1'b0;
    if (!en[1]) begin
      code_d = HS_STALL;
    end else if (bad_ls) begin
      code_d = HS_STALL;
      err_d  = 1'b1;
    end else if (win_open) begin
      code_d = HS_ACK;
    end else if (tx_ready && !tx_pending) begin
      code_d = HS_ACK;
    end else begin
      code_d = HS_NYET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_code  <= HS_STALL;
      s1_err   <= 1'b0;
      s1_attr  <= '0;
    end else begin
      s1_valid <= respond;
      s1_code  <= respond ? code_d : HS_STALL;
      s1_err   <= respond && err_d;
      if (stb) begin
        s1_attr <= '{rwake: rwake, hird: hird, lstate: lstate};
      end
    end
  end
endmodule

// File: rtl/lpm_attr_reg.sv
module lpm_attr_reg
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  lpm_attr_t attr_d,
  output lpm_attr_t attr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      attr_q <= '0;
    end else if (load) begin
      attr_q <= attr_d;
    end
  end
endmodule

// File: rtl/lpm_responder.sv
module lpm_responder
  import lpm_pkg::*;
#(
  parameter int WINDOW_CYCLES = 540
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  lpm_stb,
  input  logic [1:0]            lpm_en,
  input  logic                  tx_ready,
  input  logic                  tx_pending,
  input  logic [LPM_LS_W-1:0]   pkt_link_state,
  input  logic [LPM_HIRD_W-1:0] pkt_hird,
  input  logic                  pkt_remote_wake,
  output logic                  hs_valid,
  output logic [1:0]            hs_code,
  output logic                  rsp_irq,
  output logic [1:0]            rsp_code,
  output logic                  err_irq,
  output logic [LPM_ATTR_W-1:0] attr_q
);
  logic      win_open;
  logic      s1_valid;
  hs_code_t  s1_code;
  logic      s1_err;
  lpm_attr_t s1_attr;
  lpm_attr_t attr_s;
  logic      ack_start;

  assign ack_start = s1_valid && (s1_code == HS_ACK);

  lpm_window #(.WINDOW_CYCLES(WINDOW_CYCLES)) win_i (
    .clk    (clk),
    .rst    (rst),
    .start  (ack_start),
    .open_o (win_open)
  );

  lpm_decide dec_i (
    .clk        (clk),
    .rst        (rst),
    .stb        (lpm_stb),
    .en         (lpm_en),
    .tx_ready   (tx_ready),
    .tx_pending (tx_pending),
    .lstate     (pkt_link_state),
    .hird       (pkt_hird),
    .rwake      (pkt_remote_wake),
    .win_open   (win_open),
    .s1_valid   (s1_valid),
    .s1_code    (s1_code),
    .s1_err     (s1_err),
    .s1_attr    (s1_attr)
  );

  lpm_attr_reg attr_i (
    .clk    (clk),
    .rst    (rst),
    .load   (s1_valid),
    .attr_d (s1_attr),
    .attr_q (attr_s)
  );

  assign attr_q = attr_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_valid <= 1'b0;
      hs_code  <= 2'd0;
      rsp_irq  <= 1'b0;
      rsp_code <= 2'd0;
      err_irq  <= 1'b0;
    end else begin
      hs_valid <= s1_valid;
      hs_code  <= s1_valid ? s1_code : 2'd0;
      rsp_irq  <= s1_valid;
      rsp_code <= s1_valid ? s1_code : 2'd0;
      err_irq  <= s1_err;
    end
  end
endmodule

// File: rtl/lpm_responder_chk.sv
module lpm_responder_chk
  import lpm_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  lpm_stb,
  input logic [1:0]            lpm_en,
  input logic [LPM_LS_W-1:0]   pkt_link_state,
  input logic                  hs_valid,
  input logic [1:0]            hs_code,
  input logic                  rsp_irq,
  input logic [1:0]            rsp_code,
  input logic                  err_irq,
  input logic [LPM_ATTR_W-1:0] attr_q
);
  AST_OFF_NO_HS: assert property (@(posedge clk) disable iff (rst)
    lpm_stb && !lpm_en[0] |=> ##1 !hs_valid); // R1

  AST_EN01_STALL: assert property (@(posedge clk) disable iff (rst)
    lpm_stb && lpm_en == 2'b01 |=> ##1 (hs_valid && hs_code == 2'd0 && !err_irq)); // R2

  AST_BAD_LS_ERR: assert property (@(posedge clk) disable iff (rst)
    lpm_stb && lpm_en == 2'b11 && pkt_link_state != LS_SUSPEND
      |=> ##1 (hs_valid && hs_code == 2'd0 && err_irq)); // R3

  AST_ERR_IMPLIES_STALL: assert property (@(posedge clk) disable iff (rst)
    err_irq |-> (hs_valid && hs_code == 2'd0)); // R3

  AST_ATTR_ONLY_ON_HS: assert property (@(posedge clk) disable iff (rst)
    !$stable(attr_q) |-> hs_valid); // R6

  AST_IRQ_MATCHES_HS: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> (rsp_irq && rsp_code == hs_code)); // R7

  AST_HS_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> hs_code != 2'd3); // R7

  AST_HS_AFTER_STB: assert property (@(posedge clk) disable iff (rst)
    hs_valid |-> $past(lpm_stb, 2)); // R8
endmodule

bind lpm_responder lpm_responder_chk chk_i (
  .clk            (clk),
  .rst            (rst),
  .lpm_stb        (lpm_stb),
  .lpm_en         (lpm_en),
  .pkt_link_state (pkt_link_state),
  .hs_valid       (hs_valid),
  .hs_code        (hs_code),
  .rsp_irq        (rsp_irq),
  .rsp_code       (rsp_code),
  .err_irq        (err_irq),
  .attr_q         (attr_q)
);

// File: tb/lpm_responder_tb.sv
module lpm_responder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lpm_stb = 1'b0;
  logic [1:0] lpm_en = 2'b00;
  logic       tx_ready = 1'b0;
  logic       tx_pending = 1'b0;
  logic [3:0] pkt_link_state = 4'h0;
  logic [3:0] pkt_hird = 4'h0;
  logic       pkt_remote_wake = 1'b0;
  logic       hs_valid;
  logic [1:0] hs_code;
  logic       rsp_irq;
  logic [1:0] rsp_code;
  logic       err_irq;
  logic [8:0] attr_q;

  int  n_vec = 0;
  int  n_bad = 0;
  int  cyc = 0;
  int  ack_edge = -1000;
  bit  finished = 1'b0;
  logic [8:0] exp_attr = '0;

  lpm_responder #(.WINDOW_CYCLES(WIN)) dut_i (
    .clk(clk), .rst(rst), .lpm_stb(lpm_stb), .lpm_en(lpm_en),
    .tx_ready(tx_ready), .tx_pending(tx_pending),
    .pkt_link_state(pkt_link_state), .pkt_hird(pkt_hird),
    .pkt_remote_wake(pkt_remote_wake), .hs_valid(hs_valid),
    .hs_code(hs_code), .rsp_irq(rsp_irq), .rsp_code(rsp_code),
    .err_irq(err_irq), .attr_q(attr_q)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Packed observation: {hs_valid, hs_code, rsp_irq, rsp_code, err_irq, attr}
  function automatic logic [15:0] pack_obs(logic v, logic [1:0] c, logic ri,
                                           logic [1:0] rc, logic e, logic [8:0] a);
    return {v, c, ri, rc, e, a};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] observe();
    return pack_obs(hs_valid, hs_code, rsp_irq, rsp_code, err_irq, attr_q);
  endfunction

  task automatic idle(int k);
    repeat (k) @(negedge clk);
  endtask

  // Drive one token at a falling edge and check the two following cycles.
  task automatic send(string req, logic [1:0] en, logic xr, logic pd,
                      logic [3:0] ls, logic [3:0] hd, logic rw);
    int  s_edge;
    int  j;
    bit  resp;
    bit  err;
    logic [1:0] code;
    s_edge = cyc + 1;
    j = s_edge - ack_edge;
    err = 1'b0;
    code = 2'd0;
    resp = en[0];
    if (!en[1]) code = 2'd0;
    else if (ls != 4'h1) begin code = 2'd0; err = 1'b1; end
    else if (j >= 1 && j <= WIN) code = 2'd2;
    else if (xr && !pd) code = 2'd2;
    else code = 2'd1;

    lpm_stb = 1'b1; lpm_en = en; tx_ready = xr; tx_pending = pd;
    pkt_link_state = ls; pkt_hird = hd; pkt_remote_wake = rw;
    @(negedge clk);
    lpm_stb = 1'b0;
    check({req, " R8 early"}, observe(), pack_obs(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, exp_attr));
    @(negedge clk);
    if (resp) exp_attr = {rw, hd, ls};
    if (resp) begin
      check(req, observe(), pack_obs(1'b1, code, 1'b1, code, err, exp_attr));
      if (code == 2'd2) ack_edge = s_edge + 1;
    end else begin
      check(req, observe(), pack_obs(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, exp_attr));
    end
    @(negedge clk);
    check({req, " R8 pulse"}, observe(), pack_obs(1'b0, 2'd0, 1'b0, 2'd0, 1'b0, exp_attr));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset", observe(), '0);
    rst = 1'b0;
    @(negedge clk);
    check("R9 after reset", observe(), '0);

    // Sweep: enable code x ready x pending x LinkState, window closed each time.
    for (int e = 0; e < 4; e++) begin
      for (int x = 0; x < 2; x++) begin
        for (int p = 0; p < 2; p++) begin
          for (int l = 0; l < 4; l++) begin
            logic [3:0] ls;
            string tag;
            ls = (l == 0) ? 4'h1 : (l == 1) ? 4'h0 : (l == 2) ? 4'h2 : 4'hF;
            tag = !e[0] ? "R1" : (e == 1) ? "R2" : (ls != 4'h1) ? "R3" : "R4";
            send({tag, "/R6/R7 sweep"}, e[1:0], x[0], p[0], ls,
                 4'(e * 4 + x * 2 + p + l), l[0]);
            idle(WIN + 2);
          end
        end
      end
    end

    // Guard window tests.
    send("R4 open window", 2'b11, 1'b1, 1'b0, 4'h1, 4'h3, 1'b1);
    idle(WIN - 2);
    send("R5 last window edge", 2'b11, 1'b0, 1'b1, 4'h1, 4'h5, 1'b0);
    idle(0);
    send("R5 restarted window", 2'b11, 1'b0, 1'b0, 4'h1, 4'h6, 1'b1);
    idle(3);
    send("R3 bad LinkState in window", 2'b11, 1'b0, 1'b1, 4'h4, 4'h7, 1'b0);
    send("R1 disabled in window", 2'b10, 1'b0, 1'b1, 4'h1, 4'h8, 1'b1);
    send("R2 stall code in window", 2'b01, 1'b1, 1'b0, 4'h1, 4'h9, 1'b0);
    send("R5 ack refresh", 2'b11, 1'b0, 1'b1, 4'h1, 4'hA, 1'b1);
    idle(WIN - 1);
    send("R5 first edge outside", 2'b11, 1'b0, 1'b0, 4'h1, 4'hB, 1'b0);
    send("R4 nyet pending", 2'b11, 1'b1, 1'b1, 4'h1, 4'hC, 1'b1);

    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    exp_attr = '0;
    ack_edge = -1000;
    check("R9 reset again", observe(), '0);
    rst = 1'b0;
    @(negedge clk);
    send("R9 window closed after reset", 2'b11, 1'b0, 1'b0, 4'h1, 4'hD, 1'b0);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL R8 watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule